// File: doc/BRIEF.md
# NAND page program sequencer

This block is the host-side engine that writes one page into a raw x8 NAND flash target. A single start pulse hands it a column address, a row address and a few options. The page data then arrives byte by byte on a valid/ready stream. The sequencer drives the whole bus conversation on its own: the program-setup command, the address bytes, the data bytes and the confirm command. It then waits for the target's ready/busy line, reads the status byte and reports the outcome.

Two options cover the less common program flows. A column jump stops the data stream after a chosen number of bytes, issues the change-column command with new column bytes, and lets the rest of the data continue from there. A chained plane closes the page with the intermediate-plane command instead of the final confirm, so that a later request can finish a multi-plane program. Bus strobes are built from the block clock as three-clock write cycles and three-clock read cycles. Two minimum delays, the address-to-data delay and the confirm-to-busy delay, are counted in clocks.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, and whenever no request is active, we_n and re_n are 1, cle, ale, io_oe, busy, done and s_ready are 0.
- R2: A request begins with a write cycle carrying 80h with cle=1, ale=0. It is followed by COL_BYTES+ROW_BYTES write cycles with ale=1, cle=0, carrying the column bytes and then the row bytes, each field least significant byte first. A write cycle is latched by the target on the rising edge of we_n.
- R3: Exactly PAGE_BYTES data write cycles follow with cle=0 and ale=0. They carry the stream bytes in arrival order. s_ready is offered only while the block can take a data byte.
- R4: At least T_ADL clocks pass between the rising we_n edge of the last address byte and the falling we_n edge of the next data byte. This holds after both the initial and the jump addresses.
- R5: After the last data byte a command cycle is written: 10h when the request had chain=0, 11h when chain=1.
- R6: The ready/busy line is first examined no earlier than T_WB clocks after the confirm strobe. The status command is issued only once the target has gone busy and returned ready.
- R7: With chain=0 and rb_n high, the block writes 70h, reads status bytes with re_n low (io_oe=0) and repeats the read while bit 6 (ready) is 0. It then pulses done for one clock with err_prog = bit 0, ok = not bit 0, and stat_byte = the last byte read.
- R8: If the ready condition is not met within T_BUSY clocks of entering the busy wait, done pulses with err_tmo=1, ok=0, and no status command is written.
- R9: With jmp_en=1 and 1 <= jmp_after < PAGE_BYTES, after jmp_after data bytes the block writes 85h (cle=1), then COL_BYTES jump column bytes (ale=1, least significant first), then the remaining data. Any other jmp_after leaves the sequence unchanged.
- R10: A chained request (chain=1) ends when rb_n is high again after the confirm: done pulses with ok=1 and no status command is written.
- R11: A start pulse while busy=1 is ignored; the running sequence and its captured options are unchanged.
- R12: we_n and re_n are never low together, and cle and ale are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| chain | input | 1 | 1 = close with the intermediate-plane command |
| col_addr | input | 8*COL_BYTES | Starting column |
| row_addr | input | 8*ROW_BYTES | Page/block row address |
| jmp_en | input | 1 | Enable one column jump during data |
| jmp_after | input | clog2(PAGE_BYTES+1) | Data bytes sent before the jump |
| jmp_col | input | 8*COL_BYTES | Column after the jump |
| s_data | input | 8 | Write data byte |
| s_valid | input | 1 | s_data holds a byte |
| s_ready | output | 1 | Byte taken on a clock with s_valid |
| nf_io_out | output | 8 | Bus byte driven to the target |
| nf_io_oe | output | 1 | Bus driven by this block |
| nf_io_in | input | 8 | Bus byte from the target |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb_n | input | 1 | Target ready (1) / busy (0) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock end-of-request pulse |
| ok | output | 1 | Program passed |
| err_prog | output | 1 | Status reported a program failure |
| err_tmo | output | 1 | Ready never returned in time |
| stat_byte | output | 8 | Last status byte read |

## Verification
Each write reaches the bench model of the target on the clock after we_n was low, and the model latches the byte on that rising edge. The model compares the byte at once against the queue of expected cycles built from the requirements. The address-to-data gap is measured from that rising edge to the falling edge of the first data strobe. The busy window of the model starts T_WB-1 clocks after the confirm edge, so a status command before ready returns is caught as soon as it is latched. Results are sampled in the single clock where done is high, and the bench compares the read count and the status byte at that point.

// File: rtl/nps_pkg.sv
// Shared definitions for the NAND page program sequencer.
// Assumes an x8 target with the usual program command set.
package nps_pkg;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_ADL,
        S_DATA,
        S_JCMD,
        S_JADDR,
        S_CONF,
        S_WB,
        S_BUSY,
        S_STCMD,
        S_STRD,
        S_DONE
    } st_t;

    // Command codes placed on the bus.
    localparam logic [7:0] C_SETUP = 8'h80;
    localparam logic [7:0] C_JUMP  = 8'h85;
    localparam logic [7:0] C_FINAL = 8'h10;
    localparam logic [7:0] C_PLANE = 8'h11;
    localparam logic [7:0] C_STAT  = 8'h70;

    // Status byte fields.
    localparam int ST_FAIL_BIT = 0;
    localparam int ST_RDY_BIT  = 6;

endpackage

// File: rtl/nps_timer.sv
// Loadable down-counter used for the address-to-data delay, the
// confirm-to-busy delay and the busy-wait limit. It stops at zero.
// Assumes load has priority over counting.
module nps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Interval elapsed.
    assign zero = (cnt == '0);
endmodule

// File: rtl/nps_addr_sel.sv
// Picks one address byte out of the column and row fields: index 0 is
// the low column byte, the row bytes follow the column bytes. Column
// jumps use only the low COL_BYTES indices.
module nps_addr_sel #(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    localparam int N = COL_BYTES + ROW_BYTES,
    localparam int IW = $clog2(N + 1)
) (
    input  logic [8*COL_BYTES-1:0] col,
    input  logic [8*ROW_BYTES-1:0] row,
    input  logic [IW-1:0]          idx,
    output logic [7:0]             byte_out
);
    logic [8*N-1:0] flat;
    logic [8*N-1:0] shifted;

    // Row above column, then shift the wanted byte down to the bottom.
    always_comb begin
        flat     = {row, col};
        shifted  = flat >> {idx, 3'b000};
        byte_out = shifted[7:0];
    end
endmodule

// File: rtl/nps_ctrl.sv
// Control state machine of the page program sequencer. It produces
// three-clock write cycles (load byte, we_n low, we_n high) and
// three-clock read cycles (re_n low for two clocks, then high). Timer
// intervals are requested through tm_load/tm_val. It assumes
// T_ADL, T_WB and T_BUSY are all at least 1.
module nps_ctrl
    import nps_pkg::*;
#(
    parameter int PAGE_BYTES = 2112,
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    parameter int T_ADL      = 8,
    parameter int T_WB       = 6,
    parameter int T_BUSY     = 100000,
    parameter int TMR_W      = 17,
    localparam int COL_W     = 8 * COL_BYTES,
    localparam int ROW_W     = 8 * ROW_BYTES,
    localparam int ADDR_CYC  = COL_BYTES + ROW_BYTES,
    localparam int AIDX_W    = $clog2(ADDR_CYC + 1),
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chain,
    input  logic [COL_W-1:0]  col_addr,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic              jmp_en,
    input  logic [CNT_W-1:0]  jmp_after,
    input  logic [COL_W-1:0]  jmp_col,
    input  logic [7:0]        s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [7:0]        io_out,
    output logic              io_oe,
    input  logic [7:0]        io_in,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    input  logic              rb_n,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic              err_prog,
    output logic              err_tmo,
    output logic [7:0]        stat_byte,
    output logic              tm_load,
    output logic [TMR_W-1:0]  tm_val,
    input  logic              tm_zero,
    output logic [COL_W-1:0]  sel_col,
    output logic [ROW_W-1:0]  sel_row,
    output logic [AIDX_W-1:0] sel_idx,
    input  logic [7:0]        sel_byte
);
    st_t               st;
    logic [1:0]        ph;
    logic [AIDX_W-1:0] aidx;
    logic [CNT_W-1:0]  dcnt;
    logic [CNT_W-1:0]  jaft_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  jcol_q;
    logic [ROW_W-1:0]  row_q;
    logic              chain_q;
    logic              jpend;
    logic [7:0]        obyte;
    logic [7:0]        sbyte;
    logic [7:0]        nxt_byte;
    logic              is_wr;
    logic              wr_fire;
    logic              wr_last;
    logic              hs;
    logic              addr_last;
    logic              jaddr_last;

    // States that run a bus write cycle.
    always_comb begin
        is_wr = (st == S_CMD) || (st == S_ADDR) || (st == S_DATA) ||
                (st == S_JCMD) || (st == S_JADDR) || (st == S_CONF) ||
                (st == S_STCMD);
    end

    // Handshake and write-cycle phase qualifiers.
    assign s_ready    = (st == S_DATA) && (ph == 2'd0);
    assign hs         = s_ready && s_valid;
    assign wr_fire    = is_wr && (ph == 2'd0) && ((st != S_DATA) || s_valid);
    assign wr_last    = is_wr && (ph == 2'd2);
    assign addr_last  = (st == S_ADDR)  && (aidx == AIDX_W'(ADDR_CYC - 1));
    assign jaddr_last = (st == S_JADDR) && (aidx == AIDX_W'(COL_BYTES - 1));

    // Address byte source: jump column while in the jump address cycles.
    assign sel_col = (st == S_JADDR) ? jcol_q : col_q;
    assign sel_row = row_q;
    assign sel_idx = aidx;

    // Byte to place on the bus for the write cycle being started.
    always_comb begin
        unique case (st)
            S_CMD:           nxt_byte = C_SETUP;
            S_ADDR, S_JADDR: nxt_byte = sel_byte;
            S_DATA:          nxt_byte = s_data;
            S_JCMD:          nxt_byte = C_JUMP;
            S_CONF:          nxt_byte = chain_q ? C_PLANE : C_FINAL;
            S_STCMD:         nxt_byte = C_STAT;
            default:         nxt_byte = 8'h00;
        endcase
    end

    // Timer requests at the start of each timed interval.
    always_comb begin
        tm_load = 1'b0;
        tm_val  = '0;
        if (wr_last && (addr_last || jaddr_last)) begin
            tm_load = 1'b1;
            tm_val  = TMR_W'(T_ADL - 1);
        end else if (wr_last && (st == S_CONF)) begin
            tm_load = 1'b1;
            tm_val  = TMR_W'(T_WB - 1);
        end else if ((st == S_WB) && tm_zero) begin
            tm_load = 1'b1;
            tm_val  = TMR_W'(T_BUSY - 1);
        end
    end

    // Bus pin decode from state and phase.
    assign cle       = (st == S_CMD) || (st == S_JCMD) || (st == S_CONF) || (st == S_STCMD);
    assign ale       = (st == S_ADDR) || (st == S_JADDR);
    assign io_oe     = is_wr;
    assign io_out    = obyte;
    assign we_n      = !(is_wr && (ph == 2'd1));
    assign re_n      = !((st == S_STRD) && (ph != 2'd2));
    assign busy      = (st != S_IDLE) && (st != S_DONE);
    assign done      = (st == S_DONE);
    assign stat_byte = sbyte;

    // Sequencer: request capture, cycle phases, transitions and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            ph       <= 2'd0;
            aidx     <= '0;
            dcnt     <= '0;
            jaft_q   <= '0;
            col_q    <= '0;
            jcol_q   <= '0;
            row_q    <= '0;
            chain_q  <= 1'b0;
            jpend    <= 1'b0;
            obyte    <= 8'h00;
            sbyte    <= 8'h00;
            ok       <= 1'b0;
            err_prog <= 1'b0;
            err_tmo  <= 1'b0;
        end else begin
            if (wr_fire) begin
                obyte <= nxt_byte;
            end
            if (hs) begin
                dcnt <= dcnt + 1'b1;
            end
            if (is_wr) begin
                if (ph == 2'd0) begin
                    if (wr_fire) ph <= 2'd1;
                end else if (ph == 2'd1) begin
                    ph <= 2'd2;
                end else begin
                    ph <= 2'd0;
                end
            end
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        col_q    <= col_addr;
                        row_q    <= row_addr;
                        jcol_q   <= jmp_col;
                        jaft_q   <= jmp_after;
                        chain_q  <= chain;
                        jpend    <= jmp_en && (jmp_after != '0) &&
                                    (jmp_after < CNT_W'(PAGE_BYTES));
                        dcnt     <= '0;
                        ph       <= 2'd0;
                        ok       <= 1'b0;
                        err_prog <= 1'b0;
                        err_tmo  <= 1'b0;
                        st       <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (wr_last) begin
                        aidx <= '0;
                        st   <= S_ADDR;
                    end
                end
                S_ADDR, S_JADDR: begin
                    if (wr_last) begin
                        if (addr_last || jaddr_last) st <= S_ADL;
                        else                         aidx <= aidx + 1'b1;
                    end
                end
                S_ADL: begin
                    if (tm_zero) st <= S_DATA;
                end
                S_DATA: begin
                    if (wr_last) begin
                        if (dcnt == CNT_W'(PAGE_BYTES)) begin
                            st <= S_CONF;
                        end else if (jpend && (dcnt == jaft_q)) begin
                            jpend <= 1'b0;
                            st    <= S_JCMD;
                        end
                    end
                end
                S_JCMD: begin
                    if (wr_last) begin
                        aidx <= '0;
                        st   <= S_JADDR;
                    end
                end
                S_CONF: begin
                    if (wr_last) st <= S_WB;
                end
                S_WB: begin
                    if (tm_zero) st <= S_BUSY;
                end
                S_BUSY: begin
                    if (rb_n) begin
                        if (chain_q) begin
                            ok <= 1'b1;
                            st <= S_DONE;
                        end else begin
                            st <= S_STCMD;
                        end
                    end else if (tm_zero) begin
                        err_tmo <= 1'b1;
                        st      <= S_DONE;
                    end
                end
                S_STCMD: begin
                    if (wr_last) begin
                        ph <= 2'd0;
                        st <= S_STRD;
                    end
                end
                S_STRD: begin
                    if (ph == 2'd0) begin
                        ph <= 2'd1;
                    end else if (ph == 2'd1) begin
                        sbyte <= io_in;
                        ph    <= 2'd2;
                    end else begin
                        ph <= 2'd0;
                        if (sbyte[ST_RDY_BIT]) begin
                            err_prog <= sbyte[ST_FAIL_BIT];
                            ok       <= !sbyte[ST_FAIL_BIT];
                            st       <= S_DONE;
                        end else if (tm_zero) begin
                            err_tmo <= 1'b1;
                            st      <= S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    st <= S_IDLE;
                end
                default: begin
                    st <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_prog_seq.sv
// Top of the NAND page program sequencer. Wires the control state
// machine to its shared delay timer and the address byte selector.
// Assumes one target on the bus and a synchronous active-low reset.
module nand_prog_seq #(
    parameter int PAGE_BYTES = 2112,
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    parameter int T_ADL      = 8,
    parameter int T_WB       = 6,
    parameter int T_BUSY     = 100000,
    localparam int COL_W     = 8 * COL_BYTES,
    localparam int ROW_W     = 8 * ROW_BYTES,
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
    localparam int AIDX_W    = $clog2(COL_BYTES + ROW_BYTES + 1),
    localparam int T_BIG     = (T_WB > T_ADL) ? T_WB : T_ADL,
    localparam int T_MAX     = (T_BUSY > T_BIG) ? T_BUSY : T_BIG,
    localparam int TMR_W     = $clog2(T_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             chain,
    input  logic [COL_W-1:0] col_addr,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             jmp_en,
    input  logic [CNT_W-1:0] jmp_after,
    input  logic [COL_W-1:0] jmp_col,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic [7:0]       nf_io_out,
    output logic             nf_io_oe,
    input  logic [7:0]       nf_io_in,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    input  logic             nf_rb_n,
    output logic             busy,
    output logic             done,
    output logic             ok,
    output logic             err_prog,
    output logic             err_tmo,
    output logic [7:0]       stat_byte
);
    logic              tm_load;
    logic [TMR_W-1:0]  tm_val;
    logic              tm_zero;
    logic [COL_W-1:0]  sel_col;
    logic [ROW_W-1:0]  sel_row;
    logic [AIDX_W-1:0] sel_idx;
    logic [7:0]        sel_byte;

    nps_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES),
        .T_ADL(T_ADL), .T_WB(T_WB), .T_BUSY(T_BUSY), .TMR_W(TMR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .chain(chain),
        .col_addr(col_addr), .row_addr(row_addr), .jmp_en(jmp_en),
        .jmp_after(jmp_after), .jmp_col(jmp_col),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .io_out(nf_io_out), .io_oe(nf_io_oe), .io_in(nf_io_in),
        .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .rb_n(nf_rb_n), .busy(busy), .done(done), .ok(ok),
        .err_prog(err_prog), .err_tmo(err_tmo), .stat_byte(stat_byte),
        .tm_load(tm_load), .tm_val(tm_val), .tm_zero(tm_zero),
        .sel_col(sel_col), .sel_row(sel_row), .sel_idx(sel_idx),
        .sel_byte(sel_byte)
    );

    nps_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .val(tm_val), .zero(tm_zero)
    );

    nps_addr_sel #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_asel (
        .col(sel_col), .row(sel_row), .idx(sel_idx), .byte_out(sel_byte)
    );
endmodule

// File: rtl/nps_chk.sv
// Protocol checker for the page program sequencer, bound to the top.
// Observes ports only.
module nps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] s_data,
    input logic       s_valid,
    input logic       s_ready,
    input logic [7:0] nf_io_out,
    input logic       nf_io_oe,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic       busy,
    input logic       done,
    input logic       ok,
    input logic       err_tmo
);
    // R12: the two strobes never overlap.
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    // R12: command and address latches never overlap.
    a_r12_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R3: an accepted byte is strobed as data on the next clock.
    a_r3_hs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (!nf_we_n && !nf_cle && !nf_ale &&
                                  nf_io_out == $past(s_data)));

    // R7: the bus is released while reading status.
    a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_io_oe);

    // R7: done lasts one clock and the block is idle afterwards.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8: a timeout never reports a pass.
    a_r8_tmo_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_tmo && ok));

    // R1: with no request active the bus is quiet.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nf_we_n && nf_re_n && !nf_io_oe && !s_ready));

    // R11: a start while busy does not end the request.
    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind nand_prog_seq nps_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .nf_io_out(nf_io_out),
    .nf_io_oe(nf_io_oe), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .busy(busy), .done(done),
    .ok(ok), .err_tmo(err_tmo)
);

// File: tb/sim_nand_prog_seq.sv
// Bench: behavioural target model with an expected bus-cycle queue,
// checked on every clock at the falling edge.
module sim_nand_prog_seq;
    localparam int PB     = 8;
    localparam int TADL   = 5;
    localparam int TWB    = 6;
    localparam int TBUSY  = 40;
    localparam int CW     = $clog2(PB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, chain = 1'b0, jmp_en = 1'b0;
    logic [15:0] col_addr = '0, jmp_col = '0;
    logic [23:0] row_addr = '0;
    logic [CW-1:0] jmp_after = '0;
    logic [7:0] s_data = '0;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [7:0] nf_io_out, nf_io_in, stat_byte;
    logic nf_io_oe, nf_cle, nf_ale, nf_we_n, nf_re_n;
    logic nf_rb_n = 1'b1;
    logic busy, done, ok, err_prog, err_tmo;

    nand_prog_seq #(.PAGE_BYTES(PB), .T_ADL(TADL), .T_WB(TWB), .T_BUSY(TBUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .chain(chain),
        .col_addr(col_addr), .row_addr(row_addr), .jmp_en(jmp_en),
        .jmp_after(jmp_after), .jmp_col(jmp_col), .s_data(s_data),
        .s_valid(s_valid), .s_ready(s_ready), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_rb_n(nf_rb_n), .busy(busy), .done(done), .ok(ok),
        .err_prog(err_prog), .err_tmo(err_tmo), .stat_byte(stat_byte)
    );

    always #10 clk = ~clk;

    int vecs = 0, errs = 0, cyc = 0;
    logic [9:0] expq[$];
    string      expt[$];
    logic [7:0] dat[PB];
    int  sidx = 0, reads = 0, pend = 0, busyc = 0, busy_len = 10;
    int  addr_rise = 0;
    bit  feed = 0, gaps = 0, hs = 0, after_addr = 0, dev_went_busy = 0;
    logic pwe = 1'b1, pre = 1'b1;
    logic [7:0] stat_first = 8'h40, stat_rest = 8'h40;

    assign nf_io_in = (reads == 0) ? stat_first : stat_rest;

    task automatic fail(input string req, input string what, input int act, input int exp);
        errs++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic push(input logic c, input logic a, input logic [7:0] b, input string tag);
        expq.push_back({c, a, b});
        expt.push_back(tag);
    endtask

    // Target model, stream source and bus monitor, all at the falling edge.
    always @(negedge clk) begin
        logic [9:0] w, e;
        string t;
        cyc++;
        if (cyc > 100000) begin
            fail("WATCHDOG", "run hung", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin nf_rb_n = 1'b0; dev_went_busy = 1; busyc = busy_len; end
        end else if (busyc > 0) begin
            busyc--;
            if (busyc == 0) nf_rb_n = 1'b1;
        end
        if (rst_n && !nf_we_n && !nf_re_n) fail("R12", "we_n/re_n overlap", 0, 1);
        if (rst_n && nf_cle && nf_ale) fail("R12", "cle/ale overlap", 1, 0);
        if (!pwe && nf_we_n) begin
            w = {nf_cle, nf_ale, nf_io_out};
            vecs++;
            if (expq.size() == 0) fail("R2", "unexpected write", int'(w), 0);
            else begin
                e = expq.pop_front();
                t = expt.pop_front();
                if (w !== e) fail(t, "bus write {cle,ale,byte}", int'(w), int'(e));
            end
            if (nf_ale) begin addr_rise = cyc; after_addr = 1; end
            else after_addr = 0;
            if (nf_cle && (nf_io_out == 8'h10 || nf_io_out == 8'h11)) pend = TWB - 1;
            if (nf_cle && nf_io_out == 8'h70) begin
                vecs++;
                if (!(dev_went_busy && nf_rb_n)) fail("R6", "status before ready", int'(nf_rb_n), 1);
            end
        end
        if (pwe && !nf_we_n && !nf_cle && !nf_ale && after_addr) begin
            vecs++;
            if (cyc - addr_rise < TADL) fail("R4", "address-to-data gap", cyc - addr_rise, TADL);
            after_addr = 0;
        end
        if (!pre && nf_re_n) reads++;
        pwe = nf_we_n;
        pre = nf_re_n;
        if (hs) sidx++;
        s_valid = feed && (sidx < PB) && (!gaps || ($urandom % 3 != 0));
        s_data  = (sidx < PB) ? dat[sidx] : 8'h00;
        hs = s_valid && s_ready;
    end

    // One request: build the expected bus cycles, run, check the result.
    task automatic run_case(input string name, input logic ch, input logic je,
                            input int jaft, input logic [7:0] seed, input int blen,
                            input logic [7:0] s1, input logic [7:0] s2,
                            input int exp_reads, input logic e_ok, input logic e_fail,
                            input logic e_tmo, input bit poke);
        bit jump, with_stat;
        int n;
        for (int i = 0; i < PB; i++) dat[i] = seed + 8'(i * 37);
        jump = je && jaft > 0 && jaft < PB;
        with_stat = !ch && !e_tmo;
        push(1, 0, 8'h80, "R2");
        push(0, 1, col_addr[7:0], "R2");
        push(0, 1, col_addr[15:8], "R2");
        push(0, 1, row_addr[7:0], "R2");
        push(0, 1, row_addr[15:8], "R2");
        push(0, 1, row_addr[23:16], "R2");
        for (int i = 0; i < PB; i++) begin
            if (jump && i == jaft) begin
                push(1, 0, 8'h85, "R9");
                push(0, 1, jmp_col[7:0], "R9");
                push(0, 1, jmp_col[15:8], "R9");
            end
            push(0, 0, dat[i], je ? "R9" : "R3");
        end
        push(1, 0, ch ? 8'h11 : 8'h10, ch ? "R10" : "R5");
        if (with_stat) push(1, 0, 8'h70, "R7");
        @(negedge clk);
        busy_len = blen; stat_first = s1; stat_rest = s2;
        reads = 0; sidx = 0; hs = 0; pend = 0; busyc = 0; nf_rb_n = 1'b1;
        dev_went_busy = 0; feed = 1;
        chain = ch; jmp_en = je; jmp_after = CW'(jaft);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && n == 30) begin start = 1'b1; chain = ~ch; end
            if (poke && n == 31) begin start = 1'b0; chain = ch; end
        end
        if (!done) fail("WATCHDOG", name, 0, 1);
        vecs++;
        if ({ok, err_prog, err_tmo} !== {e_ok, e_fail, e_tmo})
            fail(e_tmo ? "R8" : (ch ? "R10" : "R7"), {name, " {ok,err_prog,err_tmo}"},
                 int'({ok, err_prog, err_tmo}), int'({e_ok, e_fail, e_tmo}));
        vecs++;
        if (reads != exp_reads) fail("R7", {name, " status reads"}, reads, exp_reads);
        if (with_stat) begin
            vecs++;
            if (stat_byte !== s2 && exp_reads > 1) fail("R7", {name, " stat_byte"}, stat_byte, s2);
            else if (exp_reads == 1 && stat_byte !== s1) fail("R7", {name, " stat_byte"}, stat_byte, s1);
        end
        vecs++;
        if (expq.size() != 0) fail(poke ? "R11" : "R2", {name, " cycles missing"}, expq.size(), 0);
        expq.delete(); expt.delete();
        feed = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        vecs++;
        if ({nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, busy, done, s_ready} !== 8'b1100_0000)
            fail("R1", "reset outputs", int'({nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, busy, done, s_ready}), 8'hC0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        vecs++;
        if ({nf_we_n, nf_re_n, nf_io_oe, busy, s_ready} !== 5'b11000)
            fail("R1", "idle outputs", int'({nf_we_n, nf_re_n, nf_io_oe, busy, s_ready}), 5'b11000);

        col_addr = 16'h0204; row_addr = 24'h030201; jmp_col = 16'h0123;
        // R2 R3 R4 R5 R6 R7 with a mid-run start pulse for R11
        run_case("pass", 0, 0, 0, 8'h11, 10, 8'h40, 8'h40, 1, 1, 0, 0, 1);
        gaps = 1;
        col_addr = 16'hA55A; row_addr = 24'h7E81C3;
        // R7 fail bit reported
        run_case("fail", 0, 0, 0, 8'h5C, 12, 8'hC1, 8'hC1, 1, 0, 1, 0, 0);
        // R7 not-ready status read is repeated
        run_case("reread", 0, 0, 0, 8'h90, 7, 8'h01, 8'h40, 2, 1, 0, 0, 0);
        // R9 column jump after three bytes, R4 after jump address
        run_case("jump3", 0, 1, 3, 8'h2A, 9, 8'h40, 8'h40, 1, 1, 0, 0, 0);
        // R9 out-of-range jump points are ignored
        run_case("jump0", 0, 1, 0, 8'h33, 9, 8'h40, 8'h40, 1, 1, 0, 0, 0);
        run_case("jumpend", 0, 1, PB, 8'h44, 9, 8'h40, 8'h40, 1, 1, 0, 0, 0);
        // R10 R5 chained plane closes with 11h, no status
        run_case("chain", 1, 0, 0, 8'h66, 3, 8'h40, 8'h40, 0, 1, 0, 0, 0);
        // R8 busy never ends
        run_case("timeout", 0, 0, 0, 8'h77, 1000, 8'h40, 8'h40, 0, 0, 0, 1, 0);
        gaps = 0;
        // R7 normal request after a timeout
        run_case("recover", 0, 0, 0, 8'hE1, 5, 8'h40, 8'h40, 1, 1, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule